// File: doc/BRIEF.md
# Modem Control Line Scanner

This block watches the modem handshake inputs of sixteen serial lines and drives their per-line control outputs. A scanner walks the lines in ascending order. For each line it compares the carrier, clear-to-send, ring and secondary-receive inputs against a stored snapshot. On the first mismatch it halts. It then records the line number in the select field, sets one change flag for each input that moved, raises done and, if enabled, the interrupt line. Software services the event and writes the control register with scan enable set. That clears the event, and scanning resumes at the line after the one reported.

To touch a line directly, software clears scan enable and waits for the busy flag to fall. It then writes the line number into the select field and reads or writes the line status register. In that register the four output bits (line enable, DTR, RTS, secondary transmit) are writable. The four input bits are read-only views of the synchronized inputs. A loopback mode feeds the line's own outputs back into its inputs. Every input passes through a two-flop capture stage before it is used.

Top module: `mdm_scanner`

## Requirements
- R1: After synchronous reset the control register and the line status register of line 0 read 0x0000, all output latches and ports are 0 and the interrupt is low.
- R2: The control register (address 0) holds: select in bits 3:0, busy in bit 4 (read-only), scan enable in bit 5, interrupt enable in bit 6, done in bit 7, loopback in bit 9, and change flags in bits 15:12 as secondary receive (12), clear to send (13), carrier (14) and ring (15). Bits 8, 10 and 11 read 0.
- R3: While scanning, the lowest-numbered line at or after the scan position whose inputs differ from the snapshot is reported: done becomes 1, select holds that line number, the flags hold exactly the differing inputs, and that line's snapshot takes the current inputs.
- R4: While done is 1 the scanner does not advance. A control write with scan enable set (and bits 10, 11 clear, and not both of bits 7 and 6 set) clears done and the flags, and scanning resumes at the line after the reported one. A control write with scan enable clear leaves done unchanged.
- R5: The interrupt output equals done AND interrupt enable.
- R6: A control write with both done (bit 7) and interrupt enable (bit 6) set, and bits 10 and 11 clear, sets done and so raises the interrupt.
- R7: Busy falls no later than two clock edges after the edge that clears scan enable. A line status write while scan enable or busy is 1 is ignored.
- R8: The line status register (address 1) of the selected line has line enable in bit 0, DTR in bit 1, RTS in bit 2, secondary transmit in bit 3, secondary receive in bit 4, CTS in bit 5, carrier in bit 6 and ring in bit 7, with bits 15:8 reading 0. Writes change only bits 3:0, and each line's latched bits 3:0 drive its four output ports.
- R9: A control write with bit 10 set clears every line's output latches, clears done and the flags, and returns the scan position to line 0.
- R10: A control write with bit 11 set clears done and the flags and returns the scan position to line 0.
- R11: In loopback mode a line's inputs are replaced by its outputs: carrier from DTR, CTS from RTS, secondary receive from secondary transmit, and ring reads 0.
- R12: A change on an input pin appears in the line status register after the second rising clock edge and not after the first.
- R13: When no line's inputs differ from its snapshot, done stays 0 while scanning.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 1 | Register select: 0 control, 1 line status |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the selected register (combinational) |
| car_i | input | 16 | Carrier detect input per line |
| cts_i | input | 16 | Clear-to-send input per line |
| ring_i | input | 16 | Ring indicator input per line |
| srx_i | input | 16 | Secondary receive input per line |
| len_o | output | 16 | Line enable output per line |
| dtr_o | output | 16 | Data terminal ready output per line |
| rts_o | output | 16 | Request to send output per line |
| stx_o | output | 16 | Secondary transmit output per line |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest case to reach is resumption after a halt. The line after the reported one must be scanned next, not line 0. Telling the two apart takes a second batch of changes made while the scanner sits halted, placed on both sides of the reported line. The stimulus first clears the scan position. It then sets one change and lets it be reported, then changes one line below and one above it while done holds. The report that must come next is the line above. Random rounds also flip random input subsets on random lines with scanning stopped. The bench expects the reports in ascending line order, each flag set matching its own model snapshot.

// File: rtl/mdm_pkg.sv
package mdm_pkg;

    localparam int NLINES = 16;
    localparam int LW     = $clog2(NLINES);
    localparam int RW     = 16;

    // control register bit positions
    localparam int C_BUSY  = 4;
    localparam int C_SCAN  = 5;
    localparam int C_IE    = 6;
    localparam int C_DONE  = 7;
    localparam int C_LOOP  = 9;
    localparam int C_CLRMX = 10;
    localparam int C_CLRSC = 11;
    localparam int C_FLAG  = 12;

    // input signals of one line; packed order matches flag bits 15:12
    typedef struct packed {
        logic ring;
        logic car;
        logic cts;
        logic srx;
    } mdm_in_t;

    // output latches of one line; packed order matches status bits 3:0
    typedef struct packed {
        logic stx;
        logic rts;
        logic dtr;
        logic len;
    } mdm_out_t;

    localparam int IW = $bits(mdm_in_t);
    localparam int OW = $bits(mdm_out_t);

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_FETCH = 2'd1,
        S_CHECK = 2'd2
    } scan_st_e;

    // loopback: line inputs taken from the line's own outputs
    function automatic mdm_in_t loop_map(input mdm_out_t o);
        mdm_in_t r;
        r.ring = 1'b0;
        r.car  = o.dtr;
        r.cts  = o.rts;
        r.srx  = o.stx;
        return r;
    endfunction

    function automatic logic [RW-1:0] pack_status(input mdm_in_t i, input mdm_out_t o);
        return {{(RW-IW-OW){1'b0}}, i, o};
    endfunction

endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/mdm_line_regs.sv
module mdm_line_regs
    import mdm_pkg::*;
#(
    parameter int N = NLINES
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_ok,
    input  logic [$clog2(N)-1:0] wr_line,
    input  mdm_out_t             wr_val,
    input  logic                 clr_all,
    output mdm_out_t [N-1:0]     lat
);
    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_line
            always_ff @(posedge clk) begin
                if (rst || clr_all) begin
                    lat[g] <= '0;
                end else if (wr_ok && wr_line == g) begin
                    lat[g] <= wr_val;
                end
            end
        end
    endgenerate

    // R7
    lat_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!wr_ok && !clr_all) |=> $stable(lat));
endmodule

// File: rtl/mdm_scan_fsm.sv
module mdm_scan_fsm
    import mdm_pkg::*;
#(
    parameter int N = NLINES
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 scan_en,
    input  logic                 done,
    input  logic                 clr,
    input  mdm_in_t [N-1:0]      eff_in,
    output logic                 busy,
    output logic                 hit,
    output logic [$clog2(N)-1:0] hit_line,
    output mdm_in_t              hit_flags
);
    localparam int PW = $clog2(N);
    localparam logic [PW-1:0] LAST = PW'(N - 1);

    scan_st_e        state;
    logic [PW-1:0]   ptr;
    mdm_in_t [N-1:0] snap;
    mdm_in_t         cur_q;
    mdm_in_t         diff_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= S_IDLE;
            ptr    <= '0;
            snap   <= '0;
            cur_q  <= '0;
            diff_q <= '0;
        end else if (clr) begin
            state <= S_IDLE;
            ptr   <= '0;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (scan_en && !done) state <= S_FETCH;
                end
                S_FETCH: begin
                    cur_q  <= eff_in[ptr];
                    diff_q <= eff_in[ptr] ^ snap[ptr];
                    state  <= S_CHECK;
                end
                S_CHECK: begin
                    if (diff_q != '0) snap[ptr] <= cur_q;
                    ptr   <= (ptr == LAST) ? '0 : ptr + 1'b1;
                    state <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    assign busy      = (state != S_IDLE);
    assign hit       = (state == S_CHECK) && (diff_q != '0) && !clr;
    assign hit_line  = ptr;
    assign hit_flags = diff_q;

    // R7
    busy_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (!scan_en && $past(!scan_en) && $past(!scan_en, 2)) |-> !busy);

    // R4
    done_halt_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && done) |=> !busy);
endmodule

// File: rtl/mdm_scanner.sv
module mdm_scanner
    import mdm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_addr,
    input  logic              reg_wr,
    input  logic [15:0]       reg_wdata,
    output logic [15:0]       reg_rdata,
    input  logic [NLINES-1:0] car_i,
    input  logic [NLINES-1:0] cts_i,
    input  logic [NLINES-1:0] ring_i,
    input  logic [NLINES-1:0] srx_i,
    output logic [NLINES-1:0] len_o,
    output logic [NLINES-1:0] dtr_o,
    output logic [NLINES-1:0] rts_o,
    output logic [NLINES-1:0] stx_o,
    output logic              irq_o
);
    // control state
    logic [LW-1:0] sel_q;
    logic          scan_en_q;
    logic          ie_q;
    logic          done_q;
    logic          loop_q;
    mdm_in_t       flags_q;

    mdm_in_t [NLINES-1:0]  raw_in;
    mdm_in_t [NLINES-1:0]  sync_in;
    mdm_in_t [NLINES-1:0]  eff_in;
    mdm_out_t [NLINES-1:0] lat;

    logic          busy;
    logic          hit;
    logic [LW-1:0] hit_line;
    mdm_in_t       hit_flags;

    logic ctl_wr, st_wr, st_wr_ok, clr_mux, clr_scan, force_done, resume;
    logic unused_wbits;

    assign ctl_wr     = reg_wr && !reg_addr;
    assign st_wr      = reg_wr && reg_addr;
    assign st_wr_ok   = st_wr && !scan_en_q && !busy;
    assign clr_mux    = ctl_wr && reg_wdata[C_CLRMX];
    assign clr_scan   = ctl_wr && (reg_wdata[C_CLRSC] || reg_wdata[C_CLRMX]);
    assign force_done = ctl_wr && reg_wdata[C_DONE] && reg_wdata[C_IE];
    assign resume     = ctl_wr && reg_wdata[C_SCAN];
    assign unused_wbits = ^{reg_wdata[15:C_FLAG], reg_wdata[8], reg_wdata[C_BUSY]};

    genvar g;
    generate
        for (g = 0; g < NLINES; g++) begin : g_pins
            assign raw_in[g] = '{ring: ring_i[g], car: car_i[g], cts: cts_i[g], srx: srx_i[g]};
            assign eff_in[g] = loop_q ? loop_map(lat[g]) : sync_in[g];
            assign len_o[g]  = lat[g].len;
            assign dtr_o[g]  = lat[g].dtr;
            assign rts_o[g]  = lat[g].rts;
            assign stx_o[g]  = lat[g].stx;
        end
    endgenerate

    mdm_sync #(.W(IW * NLINES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_in),
        .q   (sync_in)
    );

    mdm_line_regs #(.N(NLINES)) u_lines (
        .clk     (clk),
        .rst     (rst),
        .wr_ok   (st_wr_ok),
        .wr_line (sel_q),
        .wr_val  (mdm_out_t'(reg_wdata[OW-1:0])),
        .clr_all (clr_mux),
        .lat     (lat)
    );

    mdm_scan_fsm #(.N(NLINES)) u_scan (
        .clk       (clk),
        .rst       (rst),
        .scan_en   (scan_en_q),
        .done      (done_q),
        .clr       (clr_scan),
        .eff_in    (eff_in),
        .busy      (busy),
        .hit       (hit),
        .hit_line  (hit_line),
        .hit_flags (hit_flags)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q     <= '0;
            scan_en_q <= 1'b0;
            ie_q      <= 1'b0;
            done_q    <= 1'b0;
            loop_q    <= 1'b0;
            flags_q   <= '0;
        end else begin
            if (ctl_wr) begin
                sel_q     <= reg_wdata[LW-1:0];
                scan_en_q <= reg_wdata[C_SCAN];
                ie_q      <= reg_wdata[C_IE];
                loop_q    <= reg_wdata[C_LOOP];
                if (clr_scan) begin
                    done_q  <= 1'b0;
                    flags_q <= '0;
                end else if (force_done) begin
                    done_q <= 1'b1;
                end else if (resume) begin
                    done_q  <= 1'b0;
                    flags_q <= '0;
                end
            end
            if (hit) begin
                done_q  <= 1'b1;
                flags_q <= hit_flags;
                sel_q   <= hit_line;
            end
        end
    end

    assign irq_o = done_q && ie_q;

    always_comb begin
        if (reg_addr) begin
            reg_rdata = pack_status(eff_in[sel_q], lat[sel_q]);
        end else begin
            reg_rdata = {flags_q, 2'b00, loop_q, 1'b0, done_q, ie_q, scan_en_q, busy, sel_q};
        end
    end

    // R3
    hit_report_chk: assert property (@(posedge clk) disable iff (rst)
        hit |=> (done_q && sel_q == $past(hit_line) && flags_q == $past(hit_flags)));

    // R6
    force_irq_chk: assert property (@(posedge clk) disable iff (rst)
        (force_done && !clr_scan) |=> (done_q && irq_o));

    // R9
    clr_mux_chk: assert property (@(posedge clk) disable iff (rst)
        clr_mux |=> (len_o == '0 && dtr_o == '0 && rts_o == '0 && stx_o == '0 && !done_q));
endmodule

// File: tb/mdm_scanner_test.sv
module mdm_scanner_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        reg_addr;
    logic        reg_wr;
    logic [15:0] reg_wdata;
    logic [15:0] reg_rdata;
    logic [15:0] car_i, cts_i, ring_i, srx_i;
    logic [15:0] len_o, dtr_o, rts_o, stx_o;
    logic        irq_o;

    int nchk = 0;
    int nfail = 0;

    // bench model: inputs {ring,car,cts,srx}, snapshot, latches {stx,rts,dtr,len}
    logic [3:0] cur_in [16];
    logic [3:0] snap   [16];
    logic [3:0] lat_m  [16];

    always #5 clk = ~clk;

    mdm_scanner uut (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .car_i(car_i), .cts_i(cts_i), .ring_i(ring_i), .srx_i(srx_i),
        .len_o(len_o), .dtr_o(dtr_o), .rts_o(rts_o), .stx_o(stx_o),
        .irq_o(irq_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apply_in();
        for (int i = 0; i < 16; i++) begin
            srx_i[i]  = cur_in[i][0];
            cts_i[i]  = cur_in[i][1];
            car_i[i]  = cur_in[i][2];
            ring_i[i] = cur_in[i][3];
        end
    endtask

    task automatic wr(input logic a, input logic [15:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [15:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    function automatic logic [15:0] pack_out(input int b);
        logic [15:0] v;
        for (int i = 0; i < 16; i++) v[i] = lat_m[i][b];
        return v;
    endfunction

    task automatic chk_outs(input string req);
        chk(req, {len_o, dtr_o}, {pack_out(0), pack_out(1)});
        chk(req, {rts_o, stx_o}, {pack_out(2), pack_out(3)});
    endtask

    task automatic wait_done(output logic ok);
        logic [15:0] c;
        ok = 1'b0;
        for (int k = 0; k < 400 && !ok; k++) begin
            @(negedge clk);
            rd(1'b0, c);
            if (c[7]) ok = 1'b1;
        end
    endtask

    task automatic expect_hit(input int line, input string req);
        logic ok;
        logic [15:0] c;
        logic [3:0] d;
        d = cur_in[line] ^ snap[line];
        wait_done(ok);
        chk({req, " done"}, ok, 1'b1);
        rd(1'b0, c);
        chk({req, " line"}, c[3:0], line[3:0]);
        chk({req, " flags"}, c[15:12], d);
        snap[line] = cur_in[line];
    endtask

    task automatic stop_scan();
        logic [15:0] c;
        wr(1'b0, 16'h0000);
        @(negedge clk);
        @(negedge clk);
        rd(1'b0, c);
        chk("R7 busy drop", c[4], 1'b0);
    endtask

    task automatic round();
        logic [15:0] c;
        stop_scan();
        wr(1'b0, 16'h0800);            // R10 clear scan: position back to 0
        for (int k = 0; k < 3; k++) begin
            int ln, v;
            ln = $urandom % 16;
            v  = $urandom % 16;
            wr(1'b0, 16'(ln));
            wr(1'b1, 16'(v) | 16'h00F0);
            lat_m[ln] = v[3:0];
        end
        chk_outs("R8 outputs");
        for (int i = 0; i < 16; i++)
            if ($urandom % 4 == 0) cur_in[i] = cur_in[i] ^ 4'(($urandom % 15) + 1);
        apply_in();
        repeat (3) @(negedge clk);
        wr(1'b0, 16'h0060);
        for (int ln = 0; ln < 16; ln++) begin
            if ((cur_in[ln] ^ snap[ln]) != 4'h0) begin
                expect_hit(ln, "R3");
                chk("R5 irq", irq_o, 1'b1);
                wr(1'b0, 16'h0060);
            end
        end
        repeat (100) @(negedge clk);
        rd(1'b0, c);
        chk("R13 no spurious done", c[7], 1'b0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        logic [15:0] c;
        void'($urandom(32'd20517));
        rst = 1'b1; reg_addr = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
        for (int i = 0; i < 16; i++) begin
            cur_in[i] = '0; snap[i] = '0; lat_m[i] = '0;
        end
        apply_in();
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(1'b0, c); chk("R1 ctrl", c, 16'h0000);
        rd(1'b1, c); chk("R1 status", c, 16'h0000);
        chk("R1 irq", irq_o, 1'b0);
        chk_outs("R1 outputs");

        // R8 write status of line 5, upper bits ignored
        wr(1'b0, 16'h0005);
        wr(1'b1, 16'h00FA);
        lat_m[5] = 4'hA;
        rd(1'b1, c); chk("R8 status read", c, 16'h000A);
        chk_outs("R8 outputs");
        rd(1'b0, c); chk("R2 ctrl fields", c, 16'h0005);

        // R12 two-flop capture of carrier on line 5
        @(negedge clk);
        cur_in[5][2] = 1'b1; apply_in();
        @(negedge clk); rd(1'b1, c); chk("R12 after one edge", c[6], 1'b0);
        @(negedge clk); rd(1'b1, c); chk("R12 after two edges", c[6], 1'b1);

        // R11 loopback: car<-dtr(1) cts<-rts(0) srx<-stx(1) ring 0
        wr(1'b0, 16'h0205);
        rd(1'b1, c); chk("R11 loopback status", c, 16'h005A);
        rd(1'b0, c); chk("R2 loop bit", c[9], 1'b1);
        wr(1'b0, 16'h0005);

        // R7 status write ignored while scanning; R5 no irq with ie clear
        wr(1'b0, 16'h0025);
        wr(1'b1, 16'h0001);
        chk_outs("R7 ignored write");
        expect_hit(5, "R3 first");
        chk("R5 irq masked", irq_o, 1'b0);
        stop_scan();
        rd(1'b0, c); chk("R4 done kept on stop", c[7], 1'b1);

        // R6 forced interrupt
        wr(1'b0, 16'h0800);
        wr(1'b0, 16'h00C0);
        rd(1'b0, c); chk("R6 forced ctrl", c, 16'h00C0);
        chk("R6 forced irq", irq_o, 1'b1);
        wr(1'b0, 16'h0000);
        rd(1'b0, c); chk("R4 done survives write", c[7], 1'b1);
        chk("R5 irq off", irq_o, 1'b0);
        wr(1'b0, 16'h0800);
        rd(1'b0, c); chk("R10 clear scan", c, 16'h0000);

        for (int r = 0; r < 8; r++) round();

        // R4 resume after the reported line, not from 0
        stop_scan();
        wr(1'b0, 16'h0800);
        cur_in[4] = cur_in[4] ^ 4'b0100; apply_in();
        repeat (3) @(negedge clk);
        wr(1'b0, 16'h0060);
        expect_hit(4, "R4 first");
        cur_in[2] = cur_in[2] ^ 4'b0001;
        cur_in[6] = cur_in[6] ^ 4'b0010;
        apply_in();
        repeat (40) @(negedge clk);
        rd(1'b0, c); chk("R4 halted line", c[3:0], 4'd4);
        chk("R4 halted flags", c[15:12], 4'b0100);
        wr(1'b0, 16'h0060);
        expect_hit(6, "R4 next above");
        wr(1'b0, 16'h0060);
        expect_hit(2, "R4 wrapped");
        stop_scan();

        // R9 clear multiplexer
        wr(1'b0, 16'h0002);
        wr(1'b1, 16'h000F);
        lat_m[2] = 4'hF;
        chk_outs("R8 before clear");
        wr(1'b0, 16'h00C0);
        wr(1'b0, 16'h0400);
        for (int i = 0; i < 16; i++) lat_m[i] = '0;
        chk_outs("R9 outputs cleared");
        rd(1'b0, c); chk("R9 done cleared", c[7], 1'b0);
        chk("R9 irq", irq_o, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule